// File: doc/BRIEF.md
# Predicated Vector Scatter-Store Sequencer

This block turns one vector scatter-store command into a series of single 8-byte memory writes. A command carries a vector of 64-bit base addresses, a vector of 64-bit data elements, a per-byte predicate and a 5-bit unsigned immediate. Every lane whose predicate bit is set produces exactly one write. The address of that write is the lane's base element plus eight times the immediate, and its data is the lane's data element. Lanes whose predicate bit is clear produce no memory traffic at all.

The block accepts a command only while it is idle and captures all command fields at that moment. It then walks the active lanes from the lowest index upward and offers each write on a valid/ready port. After the last write it raises a one-cycle done pulse and becomes idle again. The vector width `VEC_BITS` is a parameter. It must be a multiple of 128 from 128 to 2048, which gives `VEC_BITS/64` lanes.

Top module: `scatter_store_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cmd_ready` is 1, and `wr_valid` and `done` are 0.
- R2: The write for lane e has the address `cmd_base[64e+63:64e] + 8*cmd_imm`, computed modulo 2^64 with no overflow indication, so a base of 0xFFFF_FFFF_FFFF_FFF8 with immediate 31 gives 0xF0.
- R3: The write for lane e carries `cmd_data[64e+63:64e]` as its data.
- R4: Lane e is active exactly when `cmd_pred[8e]` is 1. An inactive lane produces no write, and the other predicate bits have no effect.
- R5: Writes are issued in ascending lane order.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values. The block moves to the next lane only on a completed handshake.
- R7: `done` is a single-cycle pulse. It is raised in the cycle after the last handshake, or in the cycle after acceptance when no lane is active, and no write is issued in that cycle.
- R8: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 1 only while the block is idle, and command inputs that change, or a `cmd_valid` that is held, after acceptance have no effect on the running command.
- R9: Inactive lanes cost no cycles. The write for the next active lane is offered in the cycle immediately after acceptance or after the previous handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle; the command is taken when both are high |
| cmd_base | input | VEC_BITS | Base address vector; lane e in bits 64e+63:64e |
| cmd_data | input | VEC_BITS | Data vector; lane e in bits 64e+63:64e |
| cmd_pred | input | VEC_BITS/8 | Predicate; bit 8e governs lane e |
| cmd_imm | input | 5 | Unsigned immediate, scaled by 8 |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted by memory |
| wr_addr | output | 64 | Byte address of the write |
| wr_data | output | 64 | Doubleword to store |
| done | output | 1 | One-cycle pulse when the command has finished |

## Verification
The hardest situation to reach from the ports is a command that is busy, with memory stalling on a lane, while new command values sit on the inputs with `cmd_valid` held high. Only that combination shows that the captured command is isolated from the inputs and that the stall holds the address steady. The stimulus reaches it by keeping `cmd_valid` asserted with inverted fields for the whole run, while `wr_ready` follows an irregular pattern. Other commands use sparse predicates with noise in the ignored predicate bits, a base near 2^64 for wrap-around, and an all-zero predicate.

// File: rtl/scat_pkg.sv
package scat_pkg;
  localparam int unsigned ELEM_W = 64;
  localparam int unsigned IMM_W  = 5;

  function automatic logic [ELEM_W-1:0] lane_addr(input logic [ELEM_W-1:0] base,
                                                  input logic [IMM_W-1:0] imm);
    logic [ELEM_W-1:0] off;
    off = {{(ELEM_W-IMM_W-3){1'b0}}, imm, 3'b000};
    return base + off;
  endfunction
endpackage

// File: rtl/scat_lane_mask.sv
module scat_lane_mask #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*8-1:0] pred,
  output logic [LANES-1:0]   active
);
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    assign active[e] = pred[e*8];
  end
endmodule

// File: rtl/scat_lane_pick.sv
module scat_lane_pick #(
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pending,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int e = LANES - 1; e >= 0; e--) begin
      if (pending[e]) idx = IDX_W'(e);
    end
  end
  assign any = |pending;
endmodule

// File: rtl/scat_addr_gen.sv
module scat_addr_gen
  import scat_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [LANES*ELEM_W-1:0] base_vec,
  input  logic [LANES*ELEM_W-1:0] data_vec,
  input  logic [IMM_W-1:0]        imm,
  input  logic [IDX_W-1:0]        idx,
  output logic [ELEM_W-1:0]       addr,
  output logic [ELEM_W-1:0]       data
);
  logic [ELEM_W-1:0] base_sel;
  assign base_sel = base_vec[idx*ELEM_W +: ELEM_W];
  assign data     = data_vec[idx*ELEM_W +: ELEM_W];
  assign addr     = lane_addr(base_sel, imm);
endmodule

// File: rtl/scatter_store_seq.sv
module scatter_store_seq
  import scat_pkg::*;
#(
  parameter int unsigned VEC_BITS = 256,
  localparam int unsigned LANES  = VEC_BITS / ELEM_W,
  localparam int unsigned IDX_W  = $clog2(LANES),
  localparam int unsigned PRED_W = VEC_BITS / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [VEC_BITS-1:0] cmd_base,
  input  logic [VEC_BITS-1:0] cmd_data,
  input  logic [PRED_W-1:0]   cmd_pred,
  input  logic [IMM_W-1:0]    cmd_imm,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ELEM_W-1:0]   wr_addr,
  output logic [ELEM_W-1:0]   wr_data,
  output logic                done
);
  logic                busy_q;
  logic [VEC_BITS-1:0] base_q, data_q;
  logic [IMM_W-1:0]    imm_q;
  logic [LANES-1:0]    pend_q;

  logic [LANES-1:0]    cmd_active;
  logic                sel_any;
  logic [IDX_W-1:0]    sel_idx;
  logic                ev_accept, ev_write, ev_finish;

  scat_lane_mask #(.LANES(LANES)) u_mask (
    .pred   (cmd_pred),
    .active (cmd_active)
  );

  scat_lane_pick #(.LANES(LANES)) u_pick (
    .pending (pend_q),
    .any     (sel_any),
    .idx     (sel_idx)
  );

  scat_addr_gen #(.LANES(LANES)) u_agen (
    .base_vec (base_q),
    .data_vec (data_q),
    .imm      (imm_q),
    .idx      (sel_idx),
    .addr     (wr_addr),
    .data     (wr_data)
  );

  assign cmd_ready = !busy_q;
  assign wr_valid  = busy_q && sel_any;
  assign done      = busy_q && !sel_any;

  assign ev_accept = cmd_valid && cmd_ready;
  assign ev_write  = wr_valid && wr_ready;
  assign ev_finish = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      data_q <= '0;
      imm_q  <= '0;
      pend_q <= '0;
    end else if (ev_accept) begin
      busy_q <= 1'b1;
      base_q <= cmd_base;
      data_q <= cmd_data;
      imm_q  <= cmd_imm;
      pend_q <= cmd_active;
    end else if (ev_finish) begin
      busy_q <= 1'b0;
    end else if (ev_write) begin
      pend_q[sel_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/scatter_store_chk.sv
module scatter_store_chk #(
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [63:0]      wr_addr,
  input logic [63:0]      wr_data,
  input logic             done,
  input logic [IDX_W-1:0] sel_idx,
  input logic             ev_write
);
  // R6: a stalled write keeps its request and payload
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7: done never lasts two cycles
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: no write is offered alongside done
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  // R8: an idle block offers neither a write nor done
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!wr_valid && !done));

  // R5: after a handshake the next offered lane is strictly higher
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> (!wr_valid || (sel_idx > $past(sel_idx))));

  // R7: after a handshake either another write follows or done does
  a_r7_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> (wr_valid || done));
endmodule

bind scatter_store_seq scatter_store_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .done      (done),
  .sel_idx   (sel_idx),
  .ev_write  (ev_write)
);

// File: tb/scatter_store_seq_bench.sv
`timescale 1ns/1ps
module scatter_store_seq_bench;
  localparam int VB = 256;
  localparam int LN = VB / 64;
  localparam int PW = VB / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [VB-1:0] cmd_base = '0;
  logic [VB-1:0] cmd_data = '0;
  logic [PW-1:0] cmd_pred = '0;
  logic [4:0]    cmd_imm = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [63:0]   wr_addr, wr_data;
  logic          done;

  scatter_store_seq #(.VEC_BITS(VB)) u_scatter_store_seq (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit chk_en = 1'b0;

  // behavioural reference: a queue of expected writes {addr, data}
  logic [127:0] m_q[$];
  bit m_busy = 1'b0;
  int m_hs = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 1'b0;
      m_q.delete();
    end else if (!m_busy) begin
      if (cmd_valid) begin
        m_busy = 1'b1;
        for (int e = 0; e < LN; e++) begin
          if (cmd_pred[e*8] == 1'b1) begin
            logic [63:0] a;
            a = cmd_base[e*64 +: 64] + 64'(cmd_imm) * 64'd8;
            m_q.push_back({a, cmd_data[e*64 +: 64]});
          end
        end
      end
    end else if (m_q.size() == 0) begin
      m_busy = 1'b0;
    end else if (wr_ready) begin
      void'(m_q.pop_front());
      m_hs++;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      bit ev, ed;
      ev = m_busy && (m_q.size() > 0);
      ed = m_busy && (m_q.size() == 0);
      check(cmd_ready == !m_busy, "R8 cmd_ready", 64'(cmd_ready), 64'(!m_busy));
      check(wr_valid == ev, "R4,R9 wr_valid", 64'(wr_valid), 64'(ev));
      check(done == ed, "R7 done", 64'(done), 64'(ed));
      if (ev && wr_valid) begin
        check(wr_addr == m_q[0][127:64], "R2,R5,R6 wr_addr", wr_addr, m_q[0][127:64]);
        check(wr_data == m_q[0][63:0], "R3,R5,R6 wr_data", wr_data, m_q[0][63:0]);
      end
    end
  end

  function automatic bit ready_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 0;
      default: return ((c * 7 + 3) % 5) < 2;
    endcase
  endfunction

  task automatic run_cmd(input logic [VB-1:0] b, input logic [VB-1:0] d,
                         input logic [PW-1:0] p, input logic [4:0] im,
                         input int mode, input bit disturb);
    int exp_n, hs0, guard;
    exp_n = 0;
    for (int e = 0; e < LN; e++) exp_n += int'(p[e*8]);
    hs0 = m_hs;
    @(negedge clk); #1;
    cmd_base = b; cmd_data = d; cmd_pred = p; cmd_imm = im;
    cmd_valid = 1'b1;
    wr_ready = ready_pat(mode, cyc);
    @(negedge clk); #1;
    if (disturb) begin
      cmd_base = ~b; cmd_data = ~d; cmd_pred = ~p; cmd_imm = ~im;
    end else begin
      cmd_valid = 1'b0;
    end
    guard = 0;
    while (m_busy && guard < 300) begin
      if (disturb && m_q.size() == 0) cmd_valid = 1'b0;
      wr_ready = ready_pat(mode, cyc);
      @(negedge clk); #1;
      guard++;
    end
    cmd_valid = 1'b0;
    wr_ready = 1'b0;
    check((m_hs - hs0) == exp_n && guard < 300, "R4 write count",
          64'(m_hs - hs0), 64'(exp_n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(cmd_ready && !wr_valid && !done, "R1 reset outputs",
          {61'd0, cmd_ready, wr_valid, done}, 64'd4);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !wr_valid && !done, "R1 after release",
          {61'd0, cmd_ready, wr_valid, done}, 64'd4);
    chk_en = 1'b1;

    // all lanes active, memory always ready
    run_cmd({64'h4000, 64'h3000, 64'h2000, 64'h1000},
            {64'hDDDD, 64'hCCCC, 64'hBBBB, 64'hAAAA},
            32'h0101_0101, 5'd0, 0, 1'b0);
    // sparse predicate with noise in ignored bits, stalling memory (R4, R6)
    run_cmd({64'h48, 64'h38, 64'h28, 64'h18},
            {64'h44, 64'h33, 64'h22, 64'h11},
            32'hFEFE_01FE, 5'd3, 1, 1'b0);
    // lanes 1 and 3 only, skipping lane 0 and 2 (R9)
    run_cmd({64'hA0, 64'hB0, 64'hC0, 64'hD0},
            {64'h1, 64'h2, 64'h3, 64'h4},
            32'h0100_0100, 5'd1, 2, 1'b0);
    // wrap-around address (R2)
    run_cmd({64'h0, 64'h10, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFF8},
            {64'h5, 64'h6, 64'h7, 64'h8},
            32'h0001_0001, 5'd31, 1, 1'b0);
    // no active lane: immediate done (R7)
    run_cmd({4{64'h1234}}, {4{64'h5678}}, 32'hFEFE_FEFE, 5'd9, 0, 1'b0);
    // inputs disturbed and cmd_valid held while busy (R8)
    run_cmd({64'h7000, 64'h6000, 64'h5000, 64'h4000},
            {64'h9, 64'h8, 64'h7, 64'h6},
            32'h0101_0001, 5'd5, 2, 1'b1);
    // single top lane with slow memory
    run_cmd({64'hBEEF_0000, 64'h0, 64'h0, 64'h0},
            {64'hCAFE, 64'h0, 64'h0, 64'h0},
            32'h0100_0000, 5'd16, 2, 1'b0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual %0d expected 0 (cycle %0d)", 1, cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule